// File: doc/BRIEF.md
# Calendar Real-Time Clock Counter

This block keeps wall-clock time in calendar form. A free-running reference clock is divided by a programmable prescaler into a one-second tick. Each tick advances a set of live fields: seconds, minutes, hours, day of month, month, year and weekday. Month lengths and leap-year Februaries are taken into account, and the weekday cycles alongside the day.

Software reaches the block through a simple word-addressed register bus with single-cycle writes and a combinational read path. A command register starts, stops and clears the clock. Time is set by writing each field into a staging copy and then issuing an upload command. The upload copies every staged field into the live counters on the same clock edge, so a partially written time is never visible. A mode register enables calendar counting; it may only be changed while the clock is stopped.

Top module: `cal_rtc_top`

## Requirements
- R1: The prescaler register at offset 0x08 holds bits [21:0] of a write; upper bits are dropped. Its reset value is the `PRESC_RESET` parameter (999999 by default). While counting, the time advances once every prescaler+1 clock cycles.
- R2: In the command register at offset 0x00, writing 1 to bit 0 starts the clock and writing 1 to bit 1 stops it. A stop wins when both are written together. Bit 0 reads back 1 while running. All other read bits are 0, except bit 5.
- R3: While stopped, the live time holds and the prescaler phase stays at zero. The first advance after a start edge lands exactly prescaler+1 edges later.
- R4: Writing 1 to command bit 4 clears the live time and the prescaler phase on that write edge. After the clear, seconds, minutes and hours are 0, year is 0, and day, month and weekday are 1.
- R5: Writes to the field registers only change the staging copy, and the live value reads back unchanged. Writing 1 to command bit 5 sets bit 5, which reads 1 for exactly one cycle. On the following edge all staged fields are copied into the live time and bit 5 clears.
- R6: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R7: The day wraps to 1 after the month's last day. April, June, September and November have 30 days. February has 29 days when year mod 4 is 0, otherwise 28. Every other month has 31 days. Month 12 wraps to 1 and increments the year.
- R8: The weekday (1..7) advances on every day wrap, going from 7 back to 1. The year (0..255, years since 2000) wraps from 255 to 0.
- R9: Mode bit 0 at offset 0x04 enables calendar counting and resets to 0. The time advances only while the clock is running and this bit is 1. Mode writes made while running are ignored.
- R10: The live fields read back zero-extended at the following offsets: seconds 0x30, minutes 0x34, hours 0x38, day 0x3C, month 0x40, year 0x44, weekday 0x48. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high together with bus_en |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |

## Verification
Several properties are checked on every cycle: advances only while running with calendar mode set, a zero prescaler phase at each start, held time between events, and the stop-over-start priority. They also cover the one-cycle upload flag, the exact staged copy on the edge after it, single-step seconds, and a frozen mode register while running. The bench scenarios are the only place where month lengths, the leap-year February, the weekday and year wraps, and the clear values can be seen. The same holds for the exact number of edges between a start and the first advance.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_MODE  = 'h04;
  localparam int OFS_PRESC = 'h08;
  localparam int OFS_SEC   = 'h30;
  localparam int OFS_MIN   = 'h34;
  localparam int OFS_HOUR  = 'h38;
  localparam int OFS_MDAY  = 'h3C;
  localparam int OFS_MON   = 'h40;
  localparam int OFS_YEAR  = 'h44;
  localparam int OFS_WDAY  = 'h48;

  localparam int CB_START  = 0;
  localparam int CB_STOP   = 1;
  localparam int CB_CLEAR  = 4;
  localparam int CB_UPLOAD = 5;
  localparam int MB_CAL    = 0;

  typedef struct packed {
    logic [7:0] year;
    logic [3:0] month;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hours;
    logic [5:0] mins;
    logic [5:0] secs;
  } cal_time_t;

  function automatic cal_time_t cal_epoch();
    cal_time_t t;
    t.year  = 8'd0;
    t.month = 4'd1;
    t.mday  = 5'd1;
    t.wday  = 3'd1;
    t.hours = 5'd0;
    t.mins  = 6'd0;
    t.secs  = 6'd0;
    return t;
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    return yr[1:0] == 2'b00;
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] mo, input logic [7:0] yr);
    logic [4:0] len;
    case (mo)
      4'd2:                      len = is_leap(yr) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   len = 5'd30;
      default:                   len = 5'd31;
    endcase
    return len;
  endfunction

  function automatic cal_time_t cal_next(input cal_time_t t);
    cal_time_t n;
    n = t;
    if (t.secs < 6'd59) begin
      n.secs = t.secs + 6'd1;
    end else begin
      n.secs = 6'd0;
      if (t.mins < 6'd59) begin
        n.mins = t.mins + 6'd1;
      end else begin
        n.mins = 6'd0;
        if (t.hours < 5'd23) begin
          n.hours = t.hours + 5'd1;
        end else begin
          n.hours = 5'd0;
          n.wday  = (t.wday >= 3'd7) ? 3'd1 : t.wday + 3'd1;
          if (t.mday < month_len(t.month, t.year)) begin
            n.mday = t.mday + 5'd1;
          end else begin
            n.mday = 5'd1;
            if (t.month < 4'd12) begin
              n.month = t.month + 4'd1;
            end else begin
              n.month = 4'd1;
              n.year  = t.year + 8'd1;
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/cal_rtc_tick.sv
module cal_rtc_tick #(
  parameter int PRESC_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               clr,
  input  logic [PRESC_W-1:0] limit,
  output logic               tick,
  output logic [PRESC_W-1:0] phase
);

  logic [PRESC_W-1:0] cnt_q;

  // A limit lowered below the current count ends the second at once.
  assign tick  = run_en && (cnt_q >= limit);
  assign phase = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_en || clr || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cal_rtc_counter.sv
module cal_rtc_counter
  import cal_rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      load,
  input  logic      tick,
  input  cal_time_t stage,
  output cal_time_t now
);

  // Priority: clear, then upload, then the one-second advance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now <= cal_epoch();
    end else if (clr) begin
      now <= cal_epoch();
    end else if (load) begin
      now <= stage;
    end else if (tick) begin
      now <= cal_next(now);
    end
  end

endmodule

// File: rtl/cal_rtc_regs.sv
module cal_rtc_regs
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int PRESC_W     = 22,
  parameter int PRESC_RESET = 999999
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  cal_time_t          now,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               running,
  output logic               mode_cal,
  output logic [PRESC_W-1:0] presc,
  output cal_time_t          stage,
  output logic               load,
  output logic               clr
);

  logic wr;
  logic ctrl_wr;
  logic unused_hi;

  assign wr        = bus_en && bus_we;
  assign ctrl_wr   = wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign clr       = ctrl_wr && bus_wdata[CB_CLEAR];
  assign unused_hi = ^bus_wdata[DATA_W-1:PRESC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      load    <= 1'b0;
    end else begin
      load <= ctrl_wr && bus_wdata[CB_UPLOAD];
      if (ctrl_wr && bus_wdata[CB_STOP]) begin
        running <= 1'b0;
      end else if (ctrl_wr && bus_wdata[CB_START]) begin
        running <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cal <= 1'b0;
      presc    <= PRESC_W'(PRESC_RESET);
    end else begin
      if (wr && !running && bus_addr == ADDR_W'(OFS_MODE)) begin
        mode_cal <= bus_wdata[MB_CAL];
      end
      if (wr && bus_addr == ADDR_W'(OFS_PRESC)) begin
        presc <= bus_wdata[PRESC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= cal_epoch();
    end else if (wr) begin
      case (bus_addr)
        ADDR_W'(OFS_SEC):  stage.secs  <= bus_wdata[5:0];
        ADDR_W'(OFS_MIN):  stage.mins  <= bus_wdata[5:0];
        ADDR_W'(OFS_HOUR): stage.hours <= bus_wdata[4:0];
        ADDR_W'(OFS_MDAY): stage.mday  <= bus_wdata[4:0];
        ADDR_W'(OFS_MON):  stage.month <= bus_wdata[3:0];
        ADDR_W'(OFS_YEAR): stage.year  <= bus_wdata[7:0];
        ADDR_W'(OFS_WDAY): stage.wday  <= bus_wdata[2:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[CB_START]  = running;
        bus_rdata[CB_UPLOAD] = load;
      end
      ADDR_W'(OFS_MODE):  bus_rdata[MB_CAL] = mode_cal;
      ADDR_W'(OFS_PRESC): bus_rdata = DATA_W'(presc);
      ADDR_W'(OFS_SEC):   bus_rdata = DATA_W'(now.secs);
      ADDR_W'(OFS_MIN):   bus_rdata = DATA_W'(now.mins);
      ADDR_W'(OFS_HOUR):  bus_rdata = DATA_W'(now.hours);
      ADDR_W'(OFS_MDAY):  bus_rdata = DATA_W'(now.mday);
      ADDR_W'(OFS_MON):   bus_rdata = DATA_W'(now.month);
      ADDR_W'(OFS_YEAR):  bus_rdata = DATA_W'(now.year);
      ADDR_W'(OFS_WDAY):  bus_rdata = DATA_W'(now.wday);
      default:            bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cal_rtc_top.sv
module cal_rtc_top
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int PRESC_W     = 22,
  parameter int PRESC_RESET = 999999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  // Named internal events, also observed by the bound checker.
  logic               running;
  logic               mode_cal;
  logic               run_en;
  logic               tick;
  logic               load;
  logic               clr;
  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] phase;
  cal_time_t          stage;
  cal_time_t          now;

  assign run_en = running && mode_cal;

  cal_rtc_regs #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PRESC_W     (PRESC_W),
    .PRESC_RESET (PRESC_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .now       (now),
    .bus_rdata (bus_rdata),
    .running   (running),
    .mode_cal  (mode_cal),
    .presc     (presc),
    .stage     (stage),
    .load      (load),
    .clr       (clr)
  );

  cal_rtc_tick #(
    .PRESC_W (PRESC_W)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .clr    (clr),
    .limit  (presc),
    .tick   (tick),
    .phase  (phase)
  );

  cal_rtc_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .load  (load),
    .tick  (tick),
    .stage (stage),
    .now   (now)
  );

endmodule

// File: rtl/cal_rtc_checker.sv
module cal_rtc_checker
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 22
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_en,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               running,
  input logic               mode_cal,
  input logic               tick,
  input logic               load,
  input logic               clr,
  input logic [PRESC_W-1:0] phase,
  input cal_time_t          stage,
  input cal_time_t          now
);

  logic ctrl_wr;
  assign ctrl_wr = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_CTRL));

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (running && mode_cal)); // R9

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(mode_cal)); // R9

  AST_START_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (phase == '0)); // R3

  AST_HOLD_BETWEEN_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !clr) |=> $stable(now)); // R3

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[CB_STOP]) |=> !running); // R2

  AST_UPLOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !(ctrl_wr && bus_wdata[CB_UPLOAD])) |=> !load); // R5

  AST_UPLOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (now == $past(stage))); // R5

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !clr && now.secs < 6'd59) |=> (now.secs == $past(now.secs) + 6'd1)); // R6

endmodule

bind cal_rtc_top cal_rtc_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .PRESC_W (PRESC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .running   (running),
  .mode_cal  (mode_cal),
  .tick      (tick),
  .load      (load),
  .clr       (clr),
  .phase     (phase),
  .stage     (stage),
  .now       (now)
);

// File: tb/cal_rtc_top_bench.sv
module cal_rtc_top_bench;

  localparam int PRE = 2;  // one advance every 3 cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cal_rtc_top u_cal_rtc_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  // ---------------- behavioural reference model ----------------
  int m_s, m_mi, m_h, m_d, m_mo, m_y, m_wd;
  int st_s, st_mi, st_h, st_d, st_mo, st_y, st_wd;
  int m_run, m_mode, m_pend, m_presc, m_ph;

  function automatic int days_of(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic m_epoch();
    m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_wd = 1;
  endtask

  task automatic m_step();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0;
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_d++;
    if (m_d <= days_of(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y = (m_y + 1) % 256;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_epoch();
      st_s = 0; st_mi = 0; st_h = 0; st_d = 1; st_mo = 1; st_y = 0; st_wd = 1;
      m_run = 0; m_mode = 0; m_pend = 0; m_presc = 999999; m_ph = 0;
    end else begin
      bit w, cw, clr, adv;
      int a;
      w   = bus_en && bus_we;
      a   = int'(bus_addr);
      cw  = w && a == 0;
      clr = cw && bus_wdata[4];
      adv = (m_run != 0) && (m_mode != 0) && (m_ph >= m_presc);
      if (clr) m_epoch();
      else if (m_pend != 0) begin
        m_s = st_s; m_mi = st_mi; m_h = st_h; m_d = st_d;
        m_mo = st_mo; m_y = st_y; m_wd = st_wd;
      end else if (adv) m_step();
      if (m_run == 0 || m_mode == 0 || clr || adv) m_ph = 0; else m_ph++;
      if (w && a == 4 && m_run == 0) m_mode = int'(bus_wdata[0]);
      if (cw && bus_wdata[1]) m_run = 0;
      else if (cw && bus_wdata[0]) m_run = 1;
      m_pend = int'(cw && bus_wdata[5]);
      if (w && a == 8) m_presc = int'(bus_wdata[21:0]);
      if (w) begin
        case (a)
          'h30: st_s  = int'(bus_wdata) % 64;
          'h34: st_mi = int'(bus_wdata) % 64;
          'h38: st_h  = int'(bus_wdata) % 32;
          'h3C: st_d  = int'(bus_wdata) % 32;
          'h40: st_mo = int'(bus_wdata) % 16;
          'h44: st_y  = int'(bus_wdata) % 256;
          'h48: st_wd = int'(bus_wdata) % 8;
          default: ;
        endcase
      end
    end
  end

  function automatic int m_read(int a);
    case (a)
      'h00: return m_run + 32 * m_pend;
      'h04: return m_mode;
      'h08: return m_presc;
      'h30: return m_s;
      'h34: return m_mi;
      'h38: return m_h;
      'h3C: return m_d;
      'h40: return m_mo;
      'h44: return m_y;
      'h48: return m_wd;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      'h00: return "R2";
      'h04: return "R9";
      'h08: return "R1";
      default: return "R10";
    endcase
  endfunction

  // Every-cycle comparison, sampled mid-low-phase.
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      n_cmp++;
      if (bus_rdata !== 32'(m_read(int'(bus_addr)))) begin
        n_bad++;
        $display("FAIL %s per-cycle addr %h actual %0d expected %0d",
                 tag_of(int'(bus_addr)), bus_addr, bus_rdata, m_read(int'(bus_addr)));
      end
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] a, input int exp);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = a;
    #5;
    n_cmp++;
    if (bus_rdata !== 32'(exp)) begin
      n_bad++;
      $display("FAIL %s addr %h actual %0d expected %0d", tag, a, bus_rdata, exp);
    end
    @(negedge clk);
  endtask

  task automatic stage_all(input int s, mi, h, d, mo, y, wd);
    wr(8'h30, s); wr(8'h34, mi); wr(8'h38, h); wr(8'h3C, d);
    wr(8'h40, mo); wr(8'h44, y); wr(8'h48, wd);
  endtask

  // Stage, upload, run for exactly one advance, stop, then check every field.
  task automatic one_tick(input string tag, input int s, mi, h, d, mo, y, wd,
                          input int es, emi, eh, ed, emo, ey, ewd);
    stage_all(s, mi, h, d, mo, y, wd);
    wr(8'h00, 32'h20);
    wr(8'h00, 32'h01);
    idle(3);
    wr(8'h00, 32'h02);
    chk(tag, 8'h30, es);  chk(tag, 8'h34, emi); chk(tag, 8'h38, eh);
    chk(tag, 8'h3C, ed);  chk(tag, 8'h40, emo); chk(tag, 8'h44, ey);
    chk(tag, 8'h48, ewd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R2", 8'h00, 0);
    chk("R1", 8'h08, 999999);
    chk("R9", 8'h04, 0);
    chk("R10", 8'h3C, 1);
    chk("R10", 8'h20, 0);

    // Prescaler keeps 22 bits only
    wr(8'h08, 32'hFFC0_0002);
    chk("R1", 8'h08, PRE);
    wr(8'h04, 32'h1);
    chk("R9", 8'h04, 1);

    // Staging has no effect until upload; upload flag lasts one cycle
    stage_all(58, 59, 23, 28, 2, 1, 7);
    chk("R5", 8'h30, 0);
    wr(8'h00, 32'h20);
    chk("R5", 8'h00, 32'h20);
    chk("R5", 8'h30, 58);
    chk("R5", 8'h00, 0);

    // First second after start is full length
    wr(8'h00, 32'h01);
    chk("R3", 8'h30, 58);
    chk("R3", 8'h30, 58);
    chk("R3", 8'h30, 58);
    chk("R1", 8'h30, 59);
    chk("R2", 8'h00, 1);
    idle(1);
    wr(8'h00, 32'h02);
    chk("R6", 8'h30, 0); chk("R6", 8'h34, 0); chk("R6", 8'h38, 0);
    chk("R7", 8'h3C, 1); chk("R7", 8'h40, 3); chk("R7", 8'h44, 1);
    chk("R8", 8'h48, 1);
    chk("R3", 8'h30, 0);

    // Rollover corner cases
    one_tick("R7", 59, 59, 23, 28, 2, 4, 3,    0, 0, 0, 29, 2, 4, 4);
    one_tick("R7", 59, 59, 23, 29, 2, 4, 7,    0, 0, 0, 1, 3, 4, 1);
    one_tick("R7", 59, 59, 23, 30, 4, 9, 2,    0, 0, 0, 1, 5, 9, 3);
    one_tick("R8", 59, 59, 23, 31, 12, 255, 7, 0, 0, 0, 1, 1, 0, 1);
    one_tick("R6", 59, 59, 10, 15, 6, 20, 5,   0, 0, 11, 15, 6, 20, 5);
    one_tick("R6", 59, 34, 12, 15, 6, 20, 5,   0, 35, 12, 15, 6, 20, 5);

    // Clear command while running
    wr(8'h00, 32'h01);
    idle(4);
    wr(8'h00, 32'h11);
    chk("R4", 8'h30, 0);
    chk("R4", 8'h3C, 1);
    chk("R4", 8'h40, 1);
    chk("R4", 8'h44, 0);
    chk("R4", 8'h48, 1);
    chk("R4", 8'h38, 0);

    // Mode write ignored while running
    wr(8'h04, 32'h0);
    chk("R9", 8'h04, 1);
    wr(8'h00, 32'h02);

    // Calendar counting disabled: time holds even while running
    wr(8'h00, 32'h10);
    wr(8'h04, 32'h0);
    chk("R9", 8'h04, 0);
    wr(8'h00, 32'h01);
    idle(8);
    chk("R9", 8'h30, 0);
    wr(8'h00, 32'h02);
    wr(8'h04, 32'h1);

    // Stop wins over start
    wr(8'h00, 32'h03);
    chk("R2", 8'h00, 0);
    wr(8'h00, 32'h01);
    wr(8'h00, 32'h03);
    chk("R2", 8'h00, 0);
    idle(6);
    chk("R3", 8'h30, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule